// File: doc/BRIEF.md
# Cascade-Gated Countdown Timer

This block is a 32-bit down-counter with a word-addressed register interface. Software loads a reload value and a live count, then sets the enable bit. The counter then steps down once per clock for as long as its gating allows it. When it reaches zero it reloads. Depending on its mode bits it then keeps running, deactivates itself, or disables itself. The zero event can be routed to an interrupt line as a one-cycle pulse.

Three single-bit cascade inputs come from outside the block.

- Inputs 0 and 1 gate counting. Each one can be inverted, and the two are combined by AND or OR. Each can instead act as a one-shot trigger: once it has been seen, the counter runs on regardless of that input.
- Input 2 halts the counter. It can halt it at the next count cycle, or only when the count sits at zero at the moment the input is active.

A status output shows one of several views of the counter, chosen by a selector field, with an optional inversion:

- the zero pulse
- the active bit
- a toggle that flips on every zero event
- the count compared against two compare registers
- the enable bit

Top module: `cascade_countdown_timer`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0, and the identification word at the top word of the address window reads 0x011107E1.
- R2: While enable (control bit0) and active (control bit1) are both 1 and the gating permits, the count drops by one per clock.
- R3: A count cycle at count 0 loads the reload value. In the next cycle `irq` is high for exactly one cycle if interrupt enable (control bit4) is 1; otherwise `irq` stays 0.
- R4: At a zero reload, auto-disable (control bit2) clears both enable and active. With auto-disable 0, auto-deactivate (control bit3) clears only active, and enable stays 1.
- R5: Request-stop (control bit9) makes the next count cycle clear enable, active and request-stop while leaving the count unchanged.
- R6: Cascade-control bit0 enables cascade input 0 and bit1 inverts it. Bit2 enables input 1 and bit3 inverts it. Bit4 selects how two enabled inputs combine: 0 for AND, 1 for OR. Counting proceeds only when the combination of the enabled inputs is true. With no input enabled, counting is unconditional.
- R7: When the trigger bit of an enabled input is set (cascade-control bit6 for input 0, bit7 for input 1), the counter waits for the gate to be true once. After that it keeps counting with the gate false.
- R8: With cascade-control bit8 set and bit10 clear, an active cascade input 2 acts as request-stop. Bit9 inverts input 2.
- R9: With cascade-control bits 8 and 10 set, the counter disables itself only if input 2 is active on the zero reload. At nonzero counts, input 2 has no effect.
- R10: Word offsets are as follows:
  - 0x00 control
  - 0x04 reload
  - 0x08 count
  - 0x0C enable (bit0)
  - 0x10 cascade control (11 bits)
  - 0x14, 0x18 and 0x1C cascade source words (7 bits)
  - 0x20 compare A
  - 0x24 compare B

  A count write overrides the count step in that cycle. Writing bit0 of the control or enable word sets both enable and active to that value.
- R11: The `status` output is a function of the status select field (control bits 7:5), XORed with status invert (control bit8). The selector values are:
  - 0: zero pulse
  - 1: active
  - 2: zero toggle
  - 3: count >= A
  - 4: B <= count < A
  - 5: enable
  - 6: count <= A
  - 7: zero

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte address; bits 1:0 ignored |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| casc_in | input | 3 | Cascade inputs 0, 1, 2 |
| irq | output | 1 | One-cycle zero-event interrupt |
| status | output | 1 | Selected status view |

## Verification
A register write takes effect at the clock edge that samples it. Each count step appears at the edge after the one on which enable and active became 1. The `irq` pulse is visible during the cycle that follows the zero-count edge.

The bench drives inputs on falling edges and reads back on falling edges. It counts the rising edges between a write and the next read so that each expected count equals the preload minus that number. Cascade changes are applied on a falling edge and judged one rising edge later. Stop actions are therefore checked in the cycle that follows the edge that acts on them.

// File: rtl/cascade_countdown_timer.sv
module cascade_countdown_timer #(
  parameter int ADDR_W = 12,
  parameter int W = 32,
  parameter logic [31:0] ID_WORD = 32'h011107E1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [2:0]        casc_in,
  output logic              irq,
  output logic              status
);
  localparam int WA = ADDR_W - 2;
  localparam logic [WA-1:0] A_CTRL = 0, A_RLD = 1, A_CNT = 2, A_ENA = 3, A_CCTL = 4,
                            A_SRC0 = 5, A_SRC1 = 6, A_SRC2 = 7, A_CMPA = 8, A_CMPB = 9;
  localparam logic [WA-1:0] A_ID = {WA{1'b1}};

  logic en, act, auto_dis, auto_deact, irq_en, st_inv, req_stop;
  logic [2:0]   st_sel;
  logic [W-1:0] reload, count, cmp_a, cmp_b;
  logic [10:0]  cctl;
  logic [6:0]   src [3];
  logic zero_q, tgl, trig_hit;

  wire [WA-1:0] word = addr[ADDR_W-1:2];
  wire wr_ctrl = wr_en && word == A_CTRL;
  wire wr_cnt  = wr_en && word == A_CNT;
  wire wr_ena  = wr_en && word == A_ENA;

  wire g0 = casc_in[0] ^ cctl[1];
  wire g1 = casc_in[1] ^ cctl[3];
  wire g2 = casc_in[2] ^ cctl[9];
  logic gate;
  always_comb
    case ({cctl[2], cctl[0]})
      2'b00:   gate = 1'b1;
      2'b01:   gate = g0;
      2'b10:   gate = g1;
      default: gate = cctl[4] ? (g0 | g1) : (g0 & g1);
    endcase

  wire trig_mode = (cctl[0] & cctl[6]) | (cctl[2] & cctl[7]);
  wire gate_ok   = trig_mode ? (gate | trig_hit) : gate;
  wire run       = en & act & gate_ok;
  wire stop_now  = req_stop | (cctl[8] & ~cctl[10] & g2);
  wire at_zero   = count == '0;
  wire zero_tick = run & ~stop_now & at_zero;
  wire zero_kill = cctl[8] & cctl[10] & g2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {en, act, auto_dis, auto_deact, irq_en, st_inv, req_stop} <= '0;
      st_sel <= '0; reload <= '0; count <= '0; cmp_a <= '0; cmp_b <= '0;
      cctl <= '0; src[0] <= '0; src[1] <= '0; src[2] <= '0;
      zero_q <= 1'b0; tgl <= 1'b0; trig_hit <= 1'b0;
    end else begin
      zero_q <= zero_tick;
      if (zero_tick) tgl <= ~tgl;
      if (run) begin
        if (stop_now) begin
          en <= 1'b0; act <= 1'b0; req_stop <= 1'b0;
        end else if (at_zero) begin
          count <= reload;
          if (auto_dis | zero_kill) begin en <= 1'b0; act <= 1'b0; end
          else if (auto_deact) act <= 1'b0;
        end else count <= count - 1'b1;
      end
      if (!en) trig_hit <= 1'b0;
      else if (act & gate & trig_mode) trig_hit <= 1'b1;
      if (wr_en)
        case (word)
          A_CTRL: begin
            en <= wdata[0]; act <= wdata[0]; auto_dis <= wdata[2]; auto_deact <= wdata[3];
            irq_en <= wdata[4]; st_sel <= wdata[7:5]; st_inv <= wdata[8]; req_stop <= wdata[9];
          end
          A_RLD:  reload <= wdata[W-1:0];
          A_CNT:  count <= wdata[W-1:0];
          A_ENA:  begin en <= wdata[0]; act <= wdata[0]; end
          A_CCTL: cctl <= wdata[10:0];
          A_SRC0: src[0] <= wdata[6:0];
          A_SRC1: src[1] <= wdata[6:0];
          A_SRC2: src[2] <= wdata[6:0];
          A_CMPA: cmp_a <= wdata[W-1:0];
          A_CMPB: cmp_b <= wdata[W-1:0];
          default: ;
        endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (word)
      A_CTRL: rdata[9:0] = {req_stop, st_inv, st_sel, irq_en, auto_deact, auto_dis, act, en};
      A_RLD:  rdata[W-1:0] = reload;
      A_CNT:  rdata[W-1:0] = count;
      A_ENA:  rdata[0] = en;
      A_CCTL: rdata[10:0] = cctl;
      A_SRC0: rdata[6:0] = src[0];
      A_SRC1: rdata[6:0] = src[1];
      A_SRC2: rdata[6:0] = src[2];
      A_CMPA: rdata[W-1:0] = cmp_a;
      A_CMPB: rdata[W-1:0] = cmp_b;
      A_ID:   rdata = ID_WORD;
      default: ;
    endcase
  end

  logic st_raw;
  always_comb
    case (st_sel)
      3'd0: st_raw = zero_q;
      3'd1: st_raw = act;
      3'd2: st_raw = tgl;
      3'd3: st_raw = count >= cmp_a;
      3'd4: st_raw = (count < cmp_a) && (count >= cmp_b);
      3'd5: st_raw = en;
      3'd6: st_raw = count <= cmp_a;
      default: st_raw = 1'b0;
    endcase
  assign status = st_raw ^ st_inv;
  assign irq = zero_q & irq_en;

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    run && !stop_now && !at_zero && !wr_cnt |=> count == $past(count) - 1'b1);
  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    zero_tick && !wr_cnt && !(wr_en && word == A_RLD) |=> count == $past(reload));
  a_r4_auto_off: assert property (@(posedge clk) disable iff (!rst_n)
    zero_tick && auto_dis && !wr_ctrl && !wr_ena |=> !en && !act);
  a_r5_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    run && stop_now && !wr_ctrl && !wr_ena && !wr_cnt |=> !en && $stable(count));
  a_r6_gated: assert property (@(posedge clk) disable iff (!rst_n)
    en && act && !gate_ok && !wr_cnt |=> $stable(count));
endmodule

// File: tb/cascade_countdown_timer_bench.sv
module cascade_countdown_timer_bench;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [11:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [2:0] casc_in = 0;
  logic irq, status;
  int n_chk = 0, n_bad = 0;

  cascade_countdown_timer u_cascade_countdown_timer (.clk, .rst_n, .wr_en, .addr, .wdata,
    .rdata, .casc_in, .irq, .status);

  always #10 clk = ~clk;

  // {en0, inv0, en1, inv1, op, c0, c1, moves}
  localparam logic [7:0] GATE_VEC [12] = '{
    8'b0000_0001, 8'b1000_0101, 8'b1000_0000, 8'b1100_0001,
    8'b1100_0100, 8'b0010_0011, 8'b0011_0010, 8'b1010_0111,
    8'b1010_0100, 8'b1010_1101, 8'b1010_1000, 8'b1110_1001};

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog got=%h exp=%h", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    ticks(2); rst_n = 1; ticks(1);
    // R1 reset state
    for (int a = 0; a < 10; a++) begin rd(12'(a * 4), v); chk("R1 reg", v, 0); end
    rd(12'hFFC, v); chk("R1 id", v, 32'h011107E1);
    chk("R1 irq", {31'b0, irq}, 0);

    // R6 gating vectors
    for (int i = 0; i < 12; i++) begin
      logic [7:0] e;
      e = GATE_VEC[i];
      wr(12'h10, {27'b0, e[3], e[4], e[5], e[6], e[7]});
      casc_in = {1'b0, e[1], e[2]};
      wr(12'h08, 50);
      wr(12'h0C, 1);
      ticks(4);
      rd(12'h08, v); chk("R6 gate", v, e[0] ? 46 : 50);
      wr(12'h0C, 0);
    end
    casc_in = 0; wr(12'h10, 0);

    // R2 plain countdown, R10 count override
    wr(12'h08, 20); wr(12'h0C, 1); ticks(5);
    rd(12'h08, v); chk("R2 step", v, 15);
    wr(12'h08, 1000); rd(12'h08, v); chk("R10 count write wins", v, 1000);
    ticks(1); rd(12'h08, v); chk("R2 after override", v, 999);
    rd(12'h0C, v); chk("R10 enable read", v, 1);
    wr(12'h0C, 0);

    // R3/R4 auto-disable with irq
    wr(12'h04, 3); wr(12'h08, 2); wr(12'h00, 32'h15);
    ticks(3);
    chk("R3 irq pulse", {31'b0, irq}, 1);
    rd(12'h08, v); chk("R3 reload", v, 3);
    rd(12'h00, v); chk("R4 auto-disable", v & 3, 0);
    ticks(1); chk("R3 irq one cycle", {31'b0, irq}, 0);

    // R4 auto-deactivate, irq disabled
    wr(12'h04, 5); wr(12'h08, 1); wr(12'h00, 32'h09);
    ticks(2);
    chk("R3 no irq when masked", {31'b0, irq}, 0);
    rd(12'h00, v); chk("R4 auto-deactivate", v & 3, 1);
    ticks(1); rd(12'h08, v); chk("R4 held", v, 5);

    // R3 free running reload
    wr(12'h04, 2); wr(12'h08, 0); wr(12'h00, 32'h11);
    chk("R3 irq not yet", {31'b0, irq}, 0);
    ticks(1); chk("R3 irq first", {31'b0, irq}, 1);
    rd(12'h08, v); chk("R3 reload first", v, 2);
    ticks(1); chk("R3 irq gap", {31'b0, irq}, 0);
    ticks(2); chk("R3 irq second", {31'b0, irq}, 1);
    wr(12'h00, 0);

    // R5 request-stop
    wr(12'h08, 100); wr(12'h00, 1); ticks(3);
    rd(12'h08, v); chk("R5 pre", v, 97);
    wr(12'h00, 32'h201); ticks(1);
    rd(12'h00, v); chk("R5 stopped ctrl", v, 0);
    rd(12'h08, v); chk("R5 count kept", v, 96);

    // R8 cascade 2 immediate stop, inverted variant
    wr(12'h10, 32'h100); wr(12'h08, 50); wr(12'h0C, 1); ticks(2);
    rd(12'h08, v); chk("R8 runs", v, 48);
    casc_in[2] = 1; ticks(1);
    rd(12'h0C, v); chk("R8 stop", v, 0);
    rd(12'h08, v); chk("R8 count kept", v, 48);
    wr(12'h10, 32'h300); wr(12'h08, 50); wr(12'h0C, 1); ticks(2);
    rd(12'h08, v); chk("R8 inverted idle", v, 48);
    wr(12'h0C, 0); casc_in = 0;

    // R9 stop at zero only
    wr(12'h10, 32'h500); casc_in[2] = 1;
    wr(12'h04, 7); wr(12'h08, 2); wr(12'h0C, 1); ticks(1);
    rd(12'h0C, v); chk("R9 ignored nonzero", v, 1);
    ticks(2);
    rd(12'h0C, v); chk("R9 kill at zero", v, 0);
    rd(12'h08, v); chk("R9 reload", v, 7);
    casc_in[2] = 0;
    wr(12'h08, 1); wr(12'h0C, 1); ticks(2);
    rd(12'h0C, v); chk("R9 no kill inactive", v, 1);
    rd(12'h08, v); chk("R9 reload running", v, 7);
    wr(12'h0C, 0);

    // R7 trigger mode on input 0
    wr(12'h10, 32'h41); casc_in = 0;
    wr(12'h08, 50); wr(12'h0C, 1); ticks(2);
    rd(12'h08, v); chk("R7 waits", v, 50);
    casc_in[0] = 1; ticks(1); casc_in[0] = 0; ticks(3);
    rd(12'h08, v); chk("R7 latched", v, 46);
    wr(12'h0C, 0); wr(12'h10, 0);

    // R11 status views
    wr(12'h20, 10); wr(12'h24, 4); wr(12'h00, 32'h60); wr(12'h08, 12);
    chk("R11 ge A", {31'b0, status}, 1);
    wr(12'h08, 5); chk("R11 below A", {31'b0, status}, 0);
    wr(12'h00, 32'h160); chk("R11 invert", {31'b0, status}, 1);
    wr(12'h00, 32'h80); chk("R11 window", {31'b0, status}, 1);
    wr(12'h00, 32'hA1); chk("R11 enable view", {31'b0, status}, 1);
    wr(12'h00, 0);

    // R10 readback
    wr(12'h14, 32'hFF); rd(12'h14, v); chk("R10 source width", v, 32'h7F);
    rd(12'h24, v); chk("R10 compare B", v, 4);
    wr(12'h10, 32'hFFFF); rd(12'h10, v); chk("R10 cascade ctl", v, 32'h7FF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule